// File: doc/BRIEF.md
# Data Port Read Unit with Undefined-Bit Merge

This unit answers CPU reads of the video data port. A request is accepted when the unit is idle. If the current access code is a write code, the request finishes at once with a zero result. Otherwise the unit raises a hold line towards the slot arbiter. The arbiter then leaves its next external access slot unused and reports it through a strobe. The strobes arrive every 16 master clocks in wide mode and every 20 otherwise; that spacing belongs to the arbiter, not to this unit. In the free slot the unit reads one of three memories: video RAM, colour RAM or scroll RAM.

A video RAM read needs two free slots. The first gives the high byte from the current address. The second gives the low byte from the same address with bit 0 flipped. Colour RAM and scroll RAM hold fewer bits than the 16-bit port returns. The missing bit positions are filled from the last word that passed through the write FIFO. A scroll RAM index beyond the physical depth reads as zero.

When a memory read completes, the unit hands the address register a new value: the address plus the auto-increment. Every accepted request also clears the half-written control-word flag.

Top module: `dport_read_unit`

## Requirements
- R1: After reset, `rd_ack`, `slot_hold`, `addr_we` and `pend_clr` are low and `rd_data` is zero.
- R2: A request accepted while `code_i[0]` is 1 (write mode) gives `rd_ack` one cycle later with `rd_data` zero. It never raises `slot_hold`, uses no slot strobe and does not pulse `addr_we`.
- R3: A request accepted with `code_i[0]` 0 drives `slot_hold` high from the next cycle until the cycle that carries `rd_ack`. `rd_ack` never rises unless a `slot_unused` strobe came in while `slot_hold` was high.
- R4: With `code_i` = 4'h0 (video RAM read), the result takes two slot strobes. The high byte is `vram_rdata` at `vram_addr` = address in the first strobe. The low byte is `vram_rdata` at address with bit 0 flipped in the second strobe.
- R5: With `code_i` = 4'h8 (colour RAM read), one slot strobe is used. `cram_addr` is address bits [6:1]. The result is (`cram_rdata` & 16'h0EEE) | (`last_fifo_i` & 16'hF111).
- R6: With `code_i` = 4'h4 (scroll RAM read), one slot strobe is used, and the index is address bits [6:1]. If the index is below the depth of 40, the result is (`vsram_rdata` & 16'h03FF) | (`last_fifo_i` & 16'hFC00). Otherwise it is zero.
- R7: Any other even `code_i` completes after one slot strobe with a zero result.
- R8: Every accepted request, in write mode or not, gives a one-cycle `pend_clr` pulse in the following cycle.
- R9: In the cycle of `rd_ack` for a non-write-mode read, `addr_we` is high and `addr_next` equals `addr_i` + `autoinc_i` modulo 2^16.
- R10: `rd_ack` lasts exactly one cycle, and `rd_data` carries the result in that cycle.
- R11: A `rd_req` that comes while a read is waiting for slots is ignored. It gives no `pend_clr`, no extra `rd_ack`, and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | CPU read strobe, accepted when idle |
| code_i | input | 4 | Current access code |
| addr_i | input | 16 | Current data port address |
| autoinc_i | input | 8 | Auto-increment amount |
| last_fifo_i | input | 16 | Last word written through the write FIFO |
| slot_unused | input | 1 | Strobe: an external slot went unused |
| slot_hold | output | 1 | Read waiting: arbiter must free a slot |
| vram_addr | output | 16 | Video RAM byte address |
| vram_rdata | input | 8 | Video RAM byte read data |
| cram_addr | output | 6 | Colour RAM word index |
| cram_rdata | input | 16 | Colour RAM word |
| vsram_addr | output | 6 | Scroll RAM word index |
| vsram_rdata | input | 16 | Scroll RAM word |
| rd_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| addr_we | output | 1 | Load strobe for the address register |
| addr_next | output | 16 | Advanced address |
| pend_clr | output | 1 | Clear the half-written control-word flag |

## Verification
A wrong sequencer state shows up at the ports in two ways: `slot_hold` is stuck high or drops early, or `rd_ack` arrives after the wrong number of slot strobes. Either is visible within one slot of the fault. A stale high-byte latch or a wrong address flip shows up as a swapped or repeated byte in the video RAM result, at the ack of the affected read. A wrong fill mask or a wrong range compare changes `rd_data` on the same ack. The scroll RAM index sweep crosses the depth boundary, so an off-by-one in the compare shows up there.

// File: rtl/dport_pkg.sv
package dport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND
    } rd_state_e;

    typedef enum logic [1:0] {
        TGT_VRAM,
        TGT_CRAM,
        TGT_VSRAM,
        TGT_NONE
    } rd_target_e;

    localparam logic [3:0]  CODE_VRAM_RD  = 4'h0;
    localparam logic [3:0]  CODE_VSRAM_RD = 4'h4;
    localparam logic [3:0]  CODE_CRAM_RD  = 4'h8;
    localparam logic [15:0] CRAM_KEEP_DEF  = 16'h0EEE;
    localparam logic [15:0] VSRAM_KEEP_DEF = 16'h03FF;

    function automatic rd_target_e decode_target(input logic [3:0] code);
        case (code)
            CODE_VRAM_RD:  return TGT_VRAM;
            CODE_CRAM_RD:  return TGT_CRAM;
            CODE_VSRAM_RD: return TGT_VSRAM;
            default:       return TGT_NONE;
        endcase
    endfunction

    // stored bits where keep is set, stale FIFO bits elsewhere
    function automatic logic [15:0] fill_undef(input logic [15:0] stored,
                                               input logic [15:0] stale,
                                               input logic [15:0] keep);
        return (stored & keep) | (stale & ~keep);
    endfunction

    typedef struct packed {
        logic        ack;
        logic        we;
        logic [15:0] word;
    } rd_result_t;

endpackage

// File: rtl/dport_seq.sv
module dport_seq
    import dport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_req,
    input  logic       write_mode,
    input  rd_target_e target,
    input  logic       slot_unused,
    output logic       accept,
    output logic       in_second,
    output logic       take_first,
    output logic       slot_hold,
    output logic       done_read,
    output logic       done_write
);
    rd_state_e state_q;

    assign accept     = rd_req && (state_q == ST_IDLE);
    assign in_second  = (state_q == ST_SECOND);
    assign slot_hold  = (state_q != ST_IDLE);
    assign take_first = (state_q == ST_FIRST) && slot_unused;
    assign done_write = accept && write_mode;
    assign done_read  = (in_second && slot_unused) ||
                        (take_first && target != TGT_VRAM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (accept && !write_mode) state_q <= ST_FIRST;
                ST_FIRST:  if (slot_unused)
                               state_q <= (target == TGT_VRAM) ? ST_SECOND : ST_IDLE;
                ST_SECOND: if (slot_unused) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dport_fetch.sv
module dport_fetch
    import dport_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          CRAM_DEPTH  = 64,
    parameter int          VSRAM_DEPTH = 40,
    parameter logic [15:0] CRAM_KEEP   = CRAM_KEEP_DEF,
    parameter logic [15:0] VSRAM_KEEP  = VSRAM_KEEP_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [15:0]                   last_fifo_i,
    input  rd_target_e                    target,
    input  logic                          in_second,
    input  logic                          take_first,
    output logic [ADDR_W-1:0]             vram_addr,
    input  logic [7:0]                    vram_rdata,
    output logic [$clog2(CRAM_DEPTH)-1:0] cram_addr,
    input  logic [15:0]                   cram_rdata,
    output logic [$clog2(VSRAM_DEPTH)-1:0] vsram_addr,
    input  logic [15:0]                   vsram_rdata,
    output logic [15:0]                   word
);
    localparam int CRAM_IW  = $clog2(CRAM_DEPTH);
    localparam int VSRAM_IW = $clog2(VSRAM_DEPTH);
    localparam int VS_WRAP  = 6;  // scroll index wraps at 64 words

    logic [7:0]         hi_q;
    logic [VS_WRAP-1:0] vs_idx;
    logic               vs_in_range;

    assign vram_addr   = in_second ? (addr_i ^ ADDR_W'(1)) : addr_i;
    assign cram_addr   = addr_i[CRAM_IW:1];
    assign vs_idx      = addr_i[VS_WRAP:1];
    assign vsram_addr  = vs_idx[VSRAM_IW-1:0];
    assign vs_in_range = (int'(vs_idx) < VSRAM_DEPTH);

    always_ff @(posedge clk) begin
        if (rst)
            hi_q <= '0;
        else if (take_first && target == TGT_VRAM)
            hi_q <= vram_rdata;
    end

    always_comb begin
        case (target)
            TGT_VRAM:  word = {hi_q, vram_rdata};
            TGT_CRAM:  word = fill_undef(cram_rdata, last_fifo_i, CRAM_KEEP);
            TGT_VSRAM: word = vs_in_range ?
                              fill_undef(vsram_rdata, last_fifo_i, VSRAM_KEEP) : 16'h0000;
            default:   word = 16'h0000;
        endcase
    end
endmodule

// File: rtl/dport_resp.sv
module dport_resp
    import dport_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              done_read,
    input  logic              done_write,
    input  logic [15:0]       word,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [INC_W-1:0]  autoinc_i,
    output rd_result_t        result,
    output logic [ADDR_W-1:0] addr_next,
    output logic              pend_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            addr_next <= '0;
            pend_clr  <= 1'b0;
        end else begin
            pend_clr   <= accept;
            result.ack <= done_read || done_write;
            result.we  <= done_read;
            if (done_write)
                result.word <= 16'h0000;
            else if (done_read)
                result.word <= word;
            if (done_read)
                addr_next <= addr_i + ADDR_W'(autoinc_i);
        end
    end
endmodule

// File: rtl/dport_read_unit.sv
module dport_read_unit
    import dport_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int INC_W       = 8,
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_req,
    input  logic [3:0]                     code_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [INC_W-1:0]               autoinc_i,
    input  logic [15:0]                    last_fifo_i,
    input  logic                           slot_unused,
    output logic                           slot_hold,
    output logic [ADDR_W-1:0]              vram_addr,
    input  logic [7:0]                     vram_rdata,
    output logic [$clog2(CRAM_DEPTH)-1:0]  cram_addr,
    input  logic [15:0]                    cram_rdata,
    output logic [$clog2(VSRAM_DEPTH)-1:0] vsram_addr,
    input  logic [15:0]                    vsram_rdata,
    output logic                           rd_ack,
    output logic [15:0]                    rd_data,
    output logic                           addr_we,
    output logic [ADDR_W-1:0]              addr_next,
    output logic                           pend_clr
);
    rd_target_e target;
    rd_result_t result;
    logic       accept, in_second, take_first, done_read, done_write;
    logic [15:0] word;

    assign target = decode_target(code_i);

    dport_seq u_seq (
        .clk(clk), .rst(rst), .rd_req(rd_req), .write_mode(code_i[0]),
        .target(target), .slot_unused(slot_unused), .accept(accept),
        .in_second(in_second), .take_first(take_first), .slot_hold(slot_hold),
        .done_read(done_read), .done_write(done_write)
    );

    dport_fetch #(
        .ADDR_W(ADDR_W), .CRAM_DEPTH(CRAM_DEPTH), .VSRAM_DEPTH(VSRAM_DEPTH)
    ) u_fetch (
        .clk(clk), .rst(rst), .addr_i(addr_i), .last_fifo_i(last_fifo_i),
        .target(target), .in_second(in_second), .take_first(take_first),
        .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .cram_addr(cram_addr), .cram_rdata(cram_rdata),
        .vsram_addr(vsram_addr), .vsram_rdata(vsram_rdata), .word(word)
    );

    dport_resp #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_resp (
        .clk(clk), .rst(rst), .accept(accept), .done_read(done_read),
        .done_write(done_write), .word(word), .addr_i(addr_i),
        .autoinc_i(autoinc_i), .result(result), .addr_next(addr_next),
        .pend_clr(pend_clr)
    );

    assign rd_ack  = result.ack;
    assign addr_we = result.we;
    assign rd_data = result.word;
endmodule

// File: rtl/dport_read_chk.sv
module dport_read_chk #(
    parameter int ADDR_W = 16,
    parameter int INC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [3:0]        code_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [INC_W-1:0]  autoinc_i,
    input logic              slot_unused,
    input logic              slot_hold,
    input logic              rd_ack,
    input logic [15:0]       rd_data,
    input logic              addr_we,
    input logic [ADDR_W-1:0] addr_next,
    input logic              pend_clr
);
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);

    assert_write_quick_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !slot_hold && code_i[0]) |=> (rd_ack && rd_data == 16'h0 && !addr_we && !slot_hold));

    assert_no_ack_without_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_hold && !slot_unused) |=> !rd_ack);

    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !slot_hold) |=> pend_clr);

    assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && slot_hold) |=> !pend_clr);

    assert_addr_advance_R9: assert property (@(posedge clk) disable iff (rst)
        addr_we |-> (rd_ack && addr_next == $past(addr_i) + ADDR_W'($past(autoinc_i))));
endmodule

bind dport_read_unit dport_read_chk #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .code_i(code_i), .addr_i(addr_i),
    .autoinc_i(autoinc_i), .slot_unused(slot_unused), .slot_hold(slot_hold),
    .rd_ack(rd_ack), .rd_data(rd_data), .addr_we(addr_we),
    .addr_next(addr_next), .pend_clr(pend_clr)
);

// File: tb/tb_dport_read_unit.sv
module tb_dport_read_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [3:0]  code_i = '0;
    logic [15:0] addr_i = '0;
    logic [7:0]  autoinc_i = '0;
    logic [15:0] last_fifo_i = '0;
    logic        slot_unused = 1'b0;
    logic        slot_hold, rd_ack, addr_we, pend_clr;
    logic [15:0] vram_addr, rd_data, addr_next, cram_rdata, vsram_rdata;
    logic [7:0]  vram_rdata;
    logic [5:0]  cram_addr, vsram_addr;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [15:0] cword(input logic [5:0] i);
        return {i, i[3:0], ~i};
    endfunction
    function automatic logic [15:0] sword(input logic [5:0] i);
        return ~{i, i, i[3:0]};
    endfunction

    assign vram_rdata  = vbyte(vram_addr);
    assign cram_rdata  = cword(cram_addr);
    assign vsram_rdata = sword(vsram_addr);

    dport_read_unit dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .code_i(code_i), .addr_i(addr_i),
        .autoinc_i(autoinc_i), .last_fifo_i(last_fifo_i), .slot_unused(slot_unused),
        .slot_hold(slot_hold), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .cram_addr(cram_addr), .cram_rdata(cram_rdata), .vsram_addr(vsram_addr),
        .vsram_rdata(vsram_rdata), .rd_ack(rd_ack), .rd_data(rd_data),
        .addr_we(addr_we), .addr_next(addr_next), .pend_clr(pend_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [3:0] c, input logic [15:0] a,
                                                input logic [15:0] l);
        logic [5:0] idx;
        idx = a[6:1];
        case (c)
            4'h0: return {vbyte(a), vbyte(a ^ 16'h1)};
            4'h8: return (cword(idx) & 16'h0EEE) | (l & 16'hF111);
            4'h4: return (idx < 6'd40) ? ((sword(idx) & 16'h03FF) | (l & 16'hFC00)) : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic do_read(input logic [3:0] c, input logic [15:0] a, input logic [7:0] inc,
                           input logic [15:0] l, input int gap, input bit poke);
        int slots;
        int want_slots;
        string rq;
        logic [15:0] exp;
        rq = (c == 4'h0) ? "R4" : (c == 4'h8) ? "R5" : (c == 4'h4) ? "R6" : "R7";
        exp = expect_word(c, a, l);
        want_slots = (c == 4'h0) ? 2 : 1;
        @(negedge clk);
        code_i = c; addr_i = a; autoinc_i = inc; last_fifo_i = l; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(pend_clr == 1'b1, "R8", 32'(pend_clr), 32'h1);
        if (c[0]) begin
            chk(rd_ack && rd_data == 16'h0, "R2", {15'h0, rd_ack, rd_data}, 32'h0001_0000);
            chk(!addr_we && !slot_hold, "R2", {addr_we, slot_hold}, 32'h0);
            @(negedge clk);
            chk(!rd_ack, "R10", 32'(rd_ack), 32'h0);
            return;
        end
        chk(slot_hold && !rd_ack, "R3", {rd_ack, slot_hold}, 32'h1);
        slots = 0;
        while (!rd_ack && slots < 4) begin
            for (int g = 0; g < gap; g++) begin
                rd_req = poke;
                @(negedge clk);
                rd_req = 1'b0;
                chk(!rd_ack && slot_hold, "R3", {rd_ack, slot_hold}, 32'h1);
                if (poke) chk(!pend_clr, "R11", 32'(pend_clr), 32'h0);
            end
            slot_unused = 1'b1;
            @(negedge clk);
            slot_unused = 1'b0;
            slots++;
        end
        chk(slots == want_slots, rq, 32'(slots), 32'(want_slots));
        chk(rd_data == exp, rq, 32'(rd_data), 32'(exp));
        chk(addr_we && addr_next == a + 16'(inc), "R9", {15'h0, addr_we, addr_next},
            {16'h1, a + 16'(inc)});
        chk(!slot_hold, "R3", 32'(slot_hold), 32'h0);
        @(negedge clk);
        chk(!rd_ack && !addr_we, "R10", {rd_ack, addr_we}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_ack && !slot_hold && !addr_we && !pend_clr && rd_data == 16'h0, "R1",
            {rd_ack, slot_hold, addr_we, pend_clr, rd_data}, 32'h0);
        // stray strobe while idle must not count towards the next read
        slot_unused = 1'b1;
        @(negedge clk);
        slot_unused = 1'b0;
        chk(!rd_ack, "R3", 32'(rd_ack), 32'h0);
        for (int c = 0; c < 16; c++)
            do_read(4'(c), 16'h1234 + 16'(c * 2), 8'h02, 16'hA5C3, c % 3, 1'b0);
        for (int i = 0; i < 64; i++)
            do_read(4'h4, 16'(i * 2) + 16'(16'h0080 * (i % 4)), 8'h02,
                    16'(16'hFFFF - i * 1031), i % 2, 1'b0);
        for (int i = 0; i < 64; i++)
            do_read(4'h8, 16'(i * 2) | 16'h0001, 8'h40, 16'(16'hFFFF - i * 257), 0, 1'b0);
        for (int i = 0; i < 32; i++)
            do_read(4'h0, 16'(i * 16'h0811), 8'(i * 7), 16'h0, 1 + (i % 3), i[0]);
        do_read(4'h0, 16'hFFFF, 8'h02, 16'h0, 1, 1'b1);
        do_read(4'h8, 16'hFFF0, 8'hFF, 16'h1234, 2, 1'b1);
        do_read(4'h1, 16'h0002, 8'h02, 16'hFFFF, 0, 1'b0);
        do_read(4'h3, 16'h0004, 8'h02, 16'hFFFF, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule